// File: doc/BRIEF.md
# Planar Video Line Address Generator

This block produces the memory read requests needed to refresh a video image that is stored as three separate sample planes: luminance (Y) and two chrominance planes (U, V). Each plane has its own starting byte address and its own 16-bit unsigned line stride. Samples are one byte each and sit at successive byte addresses, four to a 32-bit word. For every image line the block asks for the Y words of that line, then the U words, then the V words. It then moves every plane's line start forward by that plane's stride and repeats until the programmed number of lines has been covered.

Each request carries a word-aligned byte address, the plane it belongs to, and two fields that the unpacking logic downstream uses: the byte lane that holds the first wanted sample and the number of wanted samples in the word. Line starts and line lengths need not be word aligned, so the first and last words of a segment may be partial. Byte order inside a word can be big-endian (the default) or little-endian. Chroma lines can carry the full luma sample count or half of it for 4:2:2 material.

A one-cycle start strobe loads the three base addresses and begins a walk. A walk in progress is dropped whenever a new start strobe arrives. A one-cycle done pulse marks the end of a walk. The memory and the return of data are outside the block.

Top module: `planar_line_addr_gen`

## Requirements
- R1: While reset is held and right after it is released, req_valid and done are both 0.
- R2: Each image line is requested as one Y segment, then one U segment, then one V segment (req_plane 0, 1, 2). Each segment covers consecutive byte addresses upward from that plane's current line start. req_addr is the byte address of the 32-bit word, with its two low bits always 0.
- R3: After a line's V segment, each plane's next line start is its previous line start plus its own 16-bit stride, zero-extended (a stride of 0xFFFF advances by 65535 bytes).
- R4: With cfg_chroma_half=0 the U and V segments hold cfg_width samples. With cfg_chroma_half=1 they hold ceil(cfg_width/2) samples.
- R5: req_lane gives the byte lane of the first wanted sample, where lane 0 is bits 7:0 and lane 3 is bits 31:24. With cfg_little_end=0, byte offset k of the word is in lane 3-k. With cfg_little_end=1 it is in lane k. The wanted samples run downward from req_lane in big-endian mode and upward in little-endian mode.
- R6: req_count (1 to 4) is the number of samples of the current segment that lie in the requested word, which covers partial first and last words.
- R7: While req_valid is 1 and req_ready is 0, the request (address, plane, lane, count) stays unchanged in the next cycle, unless start is asserted.
- R8: done is 1 for exactly one cycle, in the cycle after the final word of the last line is accepted. req_valid is 0 from then on until the next start.
- R9: If cfg_width or cfg_height is 0 at start, no request is made and done is 1 in the cycle after start.
- R10: A start strobe during a walk abandons that walk. The next request is the first word of a fresh walk using the newly presented configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle strobe: load bases and begin a walk |
| cfg_little_end | input | 1 | 1 selects little-endian sample packing |
| cfg_chroma_half | input | 1 | 1 makes chroma lines half as long as luma lines |
| cfg_width | input | WIDTH_W | Luma samples per line |
| cfg_height | input | HEIGHT_W | Lines per image |
| cfg_y_base | input | ADDR_W | Y plane first line byte address |
| cfg_u_base | input | ADDR_W | U plane first line byte address |
| cfg_v_base | input | ADDR_W | V plane first line byte address |
| cfg_y_stride | input | STRIDE_W | Y plane line stride in bytes |
| cfg_u_stride | input | STRIDE_W | U plane line stride in bytes |
| cfg_v_stride | input | STRIDE_W | V plane line stride in bytes |
| req_valid | output | 1 | A request is presented |
| req_ready | input | 1 | Memory side accepts the request this cycle |
| req_addr | output | ADDR_W | Word-aligned byte address |
| req_plane | output | 2 | 0 = Y, 1 = U, 2 = V |
| req_lane | output | log2(WORD_BYTES) | Lane of the first wanted sample |
| req_count | output | log2(WORD_BYTES)+1 | Wanted samples in this word |
| done | output | 1 | One-cycle end-of-walk pulse |

## Verification
The block keeps a byte pointer, the samples left in the current segment, the plane, the line number and three line-start registers. A fault in any of these reaches the request port within one accepted word. A bad pointer or remaining count corrupts req_addr, req_lane or req_count on the very next request. A bad line-start register only shows once the walk reaches the next line of that plane, so tests use several lines and odd strides. A bad line counter shows as done arriving early or late, or as extra words after the final line. The bench therefore compares the whole request stream word by word, and the done timing, against a model built sample by sample.

// File: rtl/pvag_pkg.sv
package pvag_pkg;

   localparam int NUM_PLANES = 3;

   typedef enum logic [1:0] {
      PL_Y = 2'd0,
      PL_U = 2'd1,
      PL_V = 2'd2
   } plane_e;

endpackage

// File: rtl/pvag_line_bank.sv
// Holds the current line-start byte address of every plane and the
// address the next line of each plane would begin at.
module pvag_line_bank #(
   parameter int ADDR_W   = 32,
   parameter int STRIDE_W = 16,
   parameter int NP       = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load,
   input  logic                         advance,
   input  logic [NP-1:0][ADDR_W-1:0]    base,
   input  logic [NP-1:0][STRIDE_W-1:0]  stride,
   output logic [NP-1:0][ADDR_W-1:0]    cur,
   output logic [NP-1:0][ADDR_W-1:0]    nxt
);

   localparam int PAD_W = ADDR_W - STRIDE_W;

   if (STRIDE_W < 1 || STRIDE_W >= ADDR_W) begin : g_bad_stride
      $error("pvag_line_bank: STRIDE_W must be in 1..ADDR_W-1");
   end

   for (genvar g = 0; g < NP; g++) begin : g_plane
      assign nxt[g] = cur[g] + {{PAD_W{1'b0}}, stride[g]};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cur[g] <= '0;
         end else if (load) begin
            cur[g] <= base[g];
         end else if (advance) begin
            cur[g] <= nxt[g];
         end
      end
   end

endmodule

// File: rtl/pvag_word_split.sv
// Works out which word the byte pointer lands in and how many of the
// remaining segment samples that word holds.
module pvag_word_split #(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 12,
   parameter int WORD_BYTES = 4
) (
   input  logic [ADDR_W-1:0]               ptr,
   input  logic [CNT_W-1:0]                rem,
   output logic [ADDR_W-1:0]               word_addr,
   output logic [$clog2(WORD_BYTES)-1:0]   offset,
   output logic [$clog2(WORD_BYTES):0]     nsamp,
   output logic                            last
);

   localparam int LB = $clog2(WORD_BYTES);
   localparam int XW = (CNT_W > LB + 1) ? CNT_W : LB + 1;

   logic [LB:0]   room;
   logic [XW-1:0] rem_x;
   logic [XW-1:0] room_x;

   assign offset    = ptr[LB-1:0];
   assign room      = (LB+1)'(WORD_BYTES) - {1'b0, offset};
   assign rem_x     = XW'(rem);
   assign room_x    = XW'(room);
   assign last      = (rem_x <= room_x);
   assign nsamp     = last ? rem_x[LB:0] : room;
   assign word_addr = {ptr[ADDR_W-1:LB], {LB{1'b0}}};

endmodule

// File: rtl/pvag_lane_map.sv
// Maps a byte offset within a word onto a physical byte lane.
module pvag_lane_map #(
   parameter int WORD_BYTES = 4
) (
   input  logic                            little,
   input  logic [$clog2(WORD_BYTES)-1:0]   offset,
   output logic [$clog2(WORD_BYTES)-1:0]   lane
);

   // For a power-of-two word, WORD_BYTES-1-k equals the bitwise complement.
   assign lane = little ? offset : ~offset;

endmodule

// File: rtl/planar_line_addr_gen.sv
module planar_line_addr_gen
   import pvag_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int STRIDE_W   = 16,
   parameter int WIDTH_W    = 12,
   parameter int HEIGHT_W   = 11,
   parameter int WORD_BYTES = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            start,
   input  logic                            cfg_little_end,
   input  logic                            cfg_chroma_half,
   input  logic [WIDTH_W-1:0]              cfg_width,
   input  logic [HEIGHT_W-1:0]             cfg_height,
   input  logic [ADDR_W-1:0]               cfg_y_base,
   input  logic [ADDR_W-1:0]               cfg_u_base,
   input  logic [ADDR_W-1:0]               cfg_v_base,
   input  logic [STRIDE_W-1:0]             cfg_y_stride,
   input  logic [STRIDE_W-1:0]             cfg_u_stride,
   input  logic [STRIDE_W-1:0]             cfg_v_stride,
   output logic                            req_valid,
   input  logic                            req_ready,
   output logic [ADDR_W-1:0]               req_addr,
   output logic [1:0]                      req_plane,
   output logic [$clog2(WORD_BYTES)-1:0]   req_lane,
   output logic [$clog2(WORD_BYTES):0]     req_count,
   output logic                            done
);

   localparam int LB = $clog2(WORD_BYTES);
   localparam int NP = NUM_PLANES;

   if (WORD_BYTES < 2 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
      $error("planar_line_addr_gen: WORD_BYTES must be a power of two >= 2");
   end
   if (WIDTH_W <= LB) begin : g_bad_width
      $error("planar_line_addr_gen: WIDTH_W must exceed log2(WORD_BYTES)");
   end
   if (HEIGHT_W < 1) begin : g_bad_height
      $error("planar_line_addr_gen: HEIGHT_W must be at least 1");
   end

   // walk state
   logic                  busy_q;
   plane_e                plane_q;
   logic [ADDR_W-1:0]     ptr_q;
   logic [WIDTH_W-1:0]    rem_q;
   logic [HEIGHT_W-1:0]   line_q;
   logic                  done_q;

   // helpers
   logic [NP-1:0][ADDR_W-1:0]   bases;
   logic [NP-1:0][STRIDE_W-1:0] strides;
   logic [NP-1:0][ADDR_W-1:0]   line_cur;
   logic [NP-1:0][ADDR_W-1:0]   line_nxt;
   logic [WIDTH_W-1:0]          chroma_len;
   logic [ADDR_W-1:0]           word_addr;
   logic [LB-1:0]               offset;
   logic [LB:0]                 nsamp;
   logic                        seg_last;
   logic                        fire;
   logic                        last_line;
   logic                        zero_dims;
   logic                        line_step;

   assign bases   = {cfg_v_base, cfg_u_base, cfg_y_base};
   assign strides = {cfg_v_stride, cfg_u_stride, cfg_y_stride};

   assign chroma_len = cfg_chroma_half
                     ? ((cfg_width >> 1) + WIDTH_W'(cfg_width[0]))
                     : cfg_width;

   assign fire      = busy_q && req_ready;
   assign last_line = (line_q == HEIGHT_W'(cfg_height - 1'b1));
   assign zero_dims = (cfg_width == '0) || (cfg_height == '0);
   assign line_step = fire && seg_last && (plane_q == PL_V) && !start;

   pvag_line_bank #(
      .ADDR_W   (ADDR_W),
      .STRIDE_W (STRIDE_W),
      .NP       (NP)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start),
      .advance (line_step),
      .base    (bases),
      .stride  (strides),
      .cur     (line_cur),
      .nxt     (line_nxt)
   );

   pvag_word_split #(
      .ADDR_W     (ADDR_W),
      .CNT_W      (WIDTH_W),
      .WORD_BYTES (WORD_BYTES)
   ) u_split (
      .ptr       (ptr_q),
      .rem       (rem_q),
      .word_addr (word_addr),
      .offset    (offset),
      .nsamp     (nsamp),
      .last      (seg_last)
   );

   pvag_lane_map #(
      .WORD_BYTES (WORD_BYTES)
   ) u_lane (
      .little (cfg_little_end),
      .offset (offset),
      .lane   (req_lane)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         plane_q <= PL_Y;
         ptr_q   <= '0;
         rem_q   <= '0;
         line_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            plane_q <= PL_Y;
            ptr_q   <= cfg_y_base;
            rem_q   <= cfg_width;
            line_q  <= '0;
            busy_q  <= !zero_dims;
            done_q  <= zero_dims;
         end else if (fire) begin
            if (!seg_last) begin
               ptr_q <= ptr_q + ADDR_W'(nsamp);
               rem_q <= rem_q - WIDTH_W'(nsamp);
            end else begin
               unique case (plane_q)
                  PL_Y: begin
                     plane_q <= PL_U;
                     ptr_q   <= line_cur[PL_U];
                     rem_q   <= chroma_len;
                  end
                  PL_U: begin
                     plane_q <= PL_V;
                     ptr_q   <= line_cur[PL_V];
                     rem_q   <= chroma_len;
                  end
                  default: begin
                     if (last_line) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                     end else begin
                        line_q  <= line_q + 1'b1;
                        plane_q <= PL_Y;
                        ptr_q   <= line_nxt[PL_Y];
                        rem_q   <= cfg_width;
                     end
                  end
               endcase
            end
         end
      end
   end

   assign req_valid = busy_q;
   assign req_addr  = word_addr;
   assign req_plane = plane_q;
   assign req_count = nsamp;
   assign done      = done_q;

endmodule

// File: rtl/pvag_checks.sv
module pvag_checks #(
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            start,
   input logic                            cfg_little_end,
   input logic                            req_valid,
   input logic                            req_ready,
   input logic [ADDR_W-1:0]               req_addr,
   input logic [1:0]                      req_plane,
   input logic [$clog2(WORD_BYTES)-1:0]   req_lane,
   input logic [$clog2(WORD_BYTES):0]     req_count,
   input logic                            done
);

   localparam int LB = $clog2(WORD_BYTES);

   p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_addr[LB-1:0] == '0));

   p_plane_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_plane != 2'd3));

   p_plane_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !start) |=>
         (!req_valid || req_plane == $past(req_plane)
          || req_plane == 2'($past(req_plane) + 2'd1)
          || (req_plane == 2'd0 && $past(req_plane) == 2'd2)));

   p_lane_fit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (cfg_little_end
                     ? (int'(req_lane) + int'(req_count) <= WORD_BYTES)
                     : (int'(req_lane) + 1 >= int'(req_count))));

   p_count_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_count != '0 && int'(req_count) <= WORD_BYTES));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready && !start) |=>
         (req_valid && $stable(req_addr) && $stable(req_plane)
          && $stable(req_lane) && $stable(req_count)));

   p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_valid);

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);

endmodule

bind planar_line_addr_gen pvag_checks #(
   .ADDR_W     (ADDR_W),
   .WORD_BYTES (WORD_BYTES)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .start          (start),
   .cfg_little_end (cfg_little_end),
   .req_valid      (req_valid),
   .req_ready      (req_ready),
   .req_addr       (req_addr),
   .req_plane      (req_plane),
   .req_lane       (req_lane),
   .req_count      (req_count),
   .done           (done)
);

// File: tb/planar_line_addr_gen_test.sv
`timescale 1ns/1ps
module planar_line_addr_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        cfg_little_end = 1'b0;
   logic        cfg_chroma_half = 1'b0;
   logic [11:0] cfg_width = '0;
   logic [10:0] cfg_height = '0;
   logic [31:0] cfg_y_base = '0, cfg_u_base = '0, cfg_v_base = '0;
   logic [15:0] cfg_y_stride = '0, cfg_u_stride = '0, cfg_v_stride = '0;
   logic        req_valid;
   logic        req_ready = 1'b0;
   logic [31:0] req_addr;
   logic [1:0]  req_plane;
   logic [1:0]  req_lane;
   logic [2:0]  req_count;
   logic        done;

   always #2.5 clk = ~clk;

   planar_line_addr_gen uut (
      .clk (clk), .rst_n (rst_n), .start (start),
      .cfg_little_end (cfg_little_end), .cfg_chroma_half (cfg_chroma_half),
      .cfg_width (cfg_width), .cfg_height (cfg_height),
      .cfg_y_base (cfg_y_base), .cfg_u_base (cfg_u_base), .cfg_v_base (cfg_v_base),
      .cfg_y_stride (cfg_y_stride), .cfg_u_stride (cfg_u_stride),
      .cfg_v_stride (cfg_v_stride),
      .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
      .req_plane (req_plane), .req_lane (req_lane), .req_count (req_count),
      .done (done)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   // expected request stream
   longint qa[$];
   int     ql[$], qc[$], qp[$], qf[$];
   bit     pend_done = 0, pend_zero = 0, restarted = 0;
   bit     held = 0, was_start = 0;
   longint held_addr = 0;
   bit     rnd_ready = 0;
   int unsigned lf = 32'h1234ACE1;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // sample-by-sample model of the whole walk
   task automatic build();
      longint base[3];
      longint strd[3];
      int     w, h, cw;
      qa.delete(); ql.delete(); qc.delete(); qp.delete(); qf.delete();
      base[0] = cfg_y_base; base[1] = cfg_u_base; base[2] = cfg_v_base;
      strd[0] = cfg_y_stride; strd[1] = cfg_u_stride; strd[2] = cfg_v_stride;
      w = cfg_width; h = cfg_height;
      cw = cfg_chroma_half ? (w + 1) / 2 : w;
      if (w == 0 || h == 0) return;
      for (int ln = 0; ln < h; ln++) begin
         for (int pl = 0; pl < 3; pl++) begin
            longint st = (base[pl] + ln * strd[pl]) & 64'hFFFF_FFFF;
            longint prevw = -1;
            int n = (pl == 0) ? w : cw;
            for (int s = 0; s < n; s++) begin
               longint b = (st + s) & 64'hFFFF_FFFF;
               longint wd = b & 64'hFFFF_FFFC;
               int off = int'(b % 4);
               if (wd != prevw) begin
                  qa.push_back(wd);
                  ql.push_back(cfg_little_end ? off : 3 - off);
                  qc.push_back(1);
                  qp.push_back(pl);
                  qf.push_back((qa.size() == 1) ? 2 : ((s == 0 && ln > 0) ? 1 : 0));
               end else begin
                  qc[qc.size()-1] = qc[qc.size()-1] + 1;
               end
               prevw = wd;
            end
         end
      end
   endtask

   task automatic tick();
      string t;
      @(negedge clk);
      start = 1'b0;
      lf = lf * 32'd1103515245 + 32'd12345;
      req_ready = rnd_ready ? lf[17] : 1'b1;
      // done timing (R8, R9)
      chk(done == pend_done, pend_zero ? "R9" : "R8", done, pend_done);
      pend_done = 0; pend_zero = 0;
      // stall hold (R7)
      if (held && !was_start) chk(req_addr == held_addr[31:0], "R7", req_addr, held_addr);
      was_start = 0;
      chk(req_valid == (qa.size() != 0), (qa.size() != 0) ? "R2" : "R8",
          req_valid, qa.size() != 0);
      if (req_valid && qa.size() != 0) begin
         if (qf[0] == 2 && restarted) t = "R10";
         else if (qf[0] == 1) t = "R3";
         else t = "R2";
         chk(req_addr == qa[0][31:0], t, req_addr, qa[0]);
         chk(req_plane == qp[0], "R2", req_plane, qp[0]);
         chk(req_lane == ql[0], "R5", req_lane, ql[0]);
         chk(req_count == qc[0], (qp[0] != 0 && cfg_chroma_half) ? "R4" : "R6",
             req_count, qc[0]);
         held = !req_ready;
         held_addr = req_addr;
         if (req_ready) begin
            void'(qa.pop_front()); void'(ql.pop_front()); void'(qc.pop_front());
            void'(qp.pop_front()); void'(qf.pop_front());
            restarted = 0;
            if (qa.size() == 0) pend_done = 1;
         end
      end else begin
         held = 0;
      end
   endtask

   task automatic kick(input bit le, input bit half, input int w, input int h,
                       input longint yb, input longint ub, input longint vb,
                       input int ys, input int us, input int vs, input bit mid);
      cfg_little_end = le; cfg_chroma_half = half;
      cfg_width = 12'(w); cfg_height = 11'(h);
      cfg_y_base = yb[31:0]; cfg_u_base = ub[31:0]; cfg_v_base = vb[31:0];
      cfg_y_stride = 16'(ys); cfg_u_stride = 16'(us); cfg_v_stride = 16'(vs);
      start = 1'b1;
      was_start = 1; held = 0;
      restarted = mid;
      build();
      pend_done = (qa.size() == 0);
      pend_zero = pend_done;
   endtask

   task automatic drain();
      int k = 0;
      while ((qa.size() != 0 || pend_done) && k < 20000) begin
         tick();
         k++;
      end
      if (k >= 20000) chk(0, "watchdog", k, 0);
      repeat (3) tick();
   endtask

   initial begin
      #950000;
      if (!finished) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_valid == 1'b0, "R1", req_valid, 0);
      chk(done == 1'b0, "R1", done, 0);
      rst_n = 1'b1;
      tick();
      chk(req_valid == 1'b0 && done == 1'b0, "R1", {req_valid, done}, 0);

      // aligned, big-endian, half chroma, always ready
      rnd_ready = 0;
      kick(0, 1, 8, 3, 32'h1000, 32'h2000, 32'h3000, 16, 8, 8, 0);
      drain();

      // unaligned, little-endian, full chroma, random ready
      rnd_ready = 1;
      kick(1, 0, 7, 4, 32'h1003, 32'h2001, 32'h3002, 'h25, 'h13, 'h0B, 0);
      drain();

      // large unsigned stride, odd width, half chroma (R3, R4)
      kick(0, 1, 5, 3, 32'h10001, 32'h20002, 32'h30003, 'hFFFF, 'hFFFF, 'h8001, 0);
      drain();

      // single-sample line, half chroma rounds up
      rnd_ready = 0;
      kick(1, 1, 1, 2, 32'h4002, 32'h5003, 32'h6001, 4, 4, 4, 0);
      drain();

      // zero dimensions (R9)
      kick(0, 0, 0, 5, 32'h100, 32'h200, 32'h300, 4, 4, 4, 0);
      drain();
      kick(1, 0, 6, 0, 32'h100, 32'h200, 32'h300, 4, 4, 4, 0);
      drain();

      // restart in the middle of a walk (R10)
      rnd_ready = 1;
      kick(1, 0, 9, 4, 32'h8001, 32'h9002, 32'hA003, 'h40, 'h40, 'h40, 0);
      repeat (9) tick();
      kick(0, 1, 6, 2, 32'hC002, 32'hD001, 32'hE003, 'h21, 'h11, 'h11, 1);
      drain();

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule